// File: doc/BRIEF.md
# Two-Round SHA-512 Compression Unit

This unit advances a SHA-512 working state by two compression rounds per invocation. The eight-word state enters as two 256-bit halves. One half carries A, B, E and F. The other carries C, D, G and H. A third 128-bit operand supplies two values, each the sum of a message word and its round constant, so the unit needs no message schedule and no constant table. The unit returns the A, B, E, F half after both rounds. After two rounds the new C, D, G, H equal the old A, B, E, F, so the caller passes the previous A, B, E, F half back in as the next C, D, G, H half. Forty invocations therefore cover a full 80-round block.

A build parameter selects the datapath. The default iterative variant applies one round per clock and takes two cycles. The fast variant chains both rounds and finishes in one cycle. Both variants use the same pulse protocol. A start pulse latches the operands, and `done_o` marks the cycle in which the result is valid.

Top module: `sha2r_twinround`

## Requirements
- R1: Each round computes T1 = CH(E,F,G) + S1(E) + WK + H, new A = T1 + MAJ(A,B,C) + S0(A) and new E = T1 + D. S0 is ror28^ror34^ror39 and S1 is ror14^ror18^ror41. CH = (E&F)^(~E&G) and MAJ = (A&B)^(A&C)^(B&C). Every addition wraps modulo 2^64.
- R2: `abef_i` and `abef_o` carry A in bits [255:192], B in [191:128], E in [127:64] and F in [63:0]. `cdgh_i` carries C in [255:192], D in [191:128], G in [127:64] and H in [63:0].
- R3: The first round uses `wk_i[63:0]` and the second round uses `wk_i[127:64]`.
- R4: Each round shifts the state: B takes the old A, C the old B, D the old C, F the old E, G the old F and H the old G.
- R5: A start is accepted at a rising edge where `start_i` is high and `busy_o` is low. In the iterative variant, `busy_o` is high during the cycle after the accepting edge and `done_o` is high during the cycle after that. In the fast variant, `done_o` is high during the cycle right after the accepting edge.
- R6: A `start_i` that arrives while `busy_o` is high has no effect. It produces no extra `done_o`, and the pending result is still computed from the operands that were first accepted.
- R7: Once `done_o` has been asserted, `abef_o` keeps its value until the next start is accepted.
- R8: After reset, `busy_o` and `done_o` are low and `abef_o` is zero.
- R9: Chaining 40 invocations on the one-block padded message "abc", then adding the initial hash words, gives the standard SHA-512 digest in both variants.
- R10: `busy_o` and `done_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request; operands are taken when it is accepted |
| abef_i | input | 256 | Current A,B,E,F half of the state |
| cdgh_i | input | 256 | Current C,D,G,H half of the state |
| wk_i | input | 128 | Two precomputed message-word-plus-constant sums |
| busy_o | output | 1 | Second round of the iterative variant is pending |
| done_o | output | 1 | `abef_o` holds a fresh result this cycle |
| abef_o | output | 256 | A,B,E,F half after two rounds |

## Verification
The assertions assume that `start_i` is a clean single-bit level that is sampled only at rising edges. They also assume that the operands stay stable only in the accepting cycle, because the unit captures them at that edge. The bench drives every input on the falling edge. It holds each start for exactly one cycle and deliberately raises a start during a busy cycle, so the ignore path is exercised. The operand values come from a small table, including all-ones words that force carry wrap-around, and from the real "abc" compression.

// File: rtl/sha2r_pkg.sv
// Shared types and round primitives for the two-round SHA-512 unit.
// Assumes 64-bit words as fixed by the algorithm.
package sha2r_pkg;
    localparam int WORD_W = 64;
    localparam int HALF_W = 4 * WORD_W;
    localparam int WK_W   = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a, b, c, d, e, f, g, h;
    } st8_t;

    // rotate right by a constant amount
    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_s0(input word_t x);
        return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
    endfunction

    function automatic word_t big_s1(input word_t x);
        return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
    endfunction

    function automatic word_t maj3(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction
endpackage

// File: rtl/sha2r_round.sv
// One combinational SHA-512 compression round.
// Assumes wk is the message word already added to its round constant.
module sha2r_round
    import sha2r_pkg::*;
(
    input  st8_t  cur,
    input  word_t wk,
    output st8_t  nxt
);
    word_t t1;
    word_t t2;

    // form the two temporaries and the shifted state
    always_comb begin
        t1    = choose(cur.e, cur.f, cur.g) + big_s1(cur.e) + wk + cur.h;
        t2    = maj3(cur.a, cur.b, cur.c) + big_s0(cur.a);
        nxt.a = t1 + t2;
        nxt.b = cur.a;
        nxt.c = cur.b;
        nxt.d = cur.c;
        nxt.e = cur.d + t1;
        nxt.f = cur.e;
        nxt.g = cur.f;
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sha2r_datapath.sv
// State register and round logic. FAST=1 chains two rounds in one cycle.
// FAST=0 reuses one round over two cycles and keeps the second WK in a register.
// Assumes load and step are never high together (the controller guarantees it).
module sha2r_datapath
    import sha2r_pkg::*;
#(
    parameter bit FAST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [HALF_W-1:0] abef_i,
    input  logic [HALF_W-1:0] cdgh_i,
    input  logic [WK_W-1:0]   wk_i,
    output st8_t              st_q
);
    st8_t  st_in;
    st8_t  st_d;
    logic  st_en;

    // unpack the two operand halves into the eight-word state
    always_comb begin
        st_in.a = abef_i[4*WORD_W-1:3*WORD_W];
        st_in.b = abef_i[3*WORD_W-1:2*WORD_W];
        st_in.e = abef_i[2*WORD_W-1:WORD_W];
        st_in.f = abef_i[WORD_W-1:0];
        st_in.c = cdgh_i[4*WORD_W-1:3*WORD_W];
        st_in.d = cdgh_i[3*WORD_W-1:2*WORD_W];
        st_in.g = cdgh_i[2*WORD_W-1:WORD_W];
        st_in.h = cdgh_i[WORD_W-1:0];
    end

    generate
        if (FAST) begin : g_fast
            st8_t mid;
            sha2r_round u_r0 (.cur(st_in), .wk(wk_i[WORD_W-1:0]),      .nxt(mid));
            sha2r_round u_r1 (.cur(mid),   .wk(wk_i[WK_W-1:WORD_W]),   .nxt(st_d));
            assign st_en = load;
        end else begin : g_iter
            word_t wk1_q;
            st8_t  rin;
            word_t wsel;

            // keep the second-round WK until the step cycle
            always_ff @(posedge clk) begin
                if (!rst_n)    wk1_q <= '0;
                else if (load) wk1_q <= wk_i[WK_W-1:WORD_W];
            end

            // pick round input: fresh operands on load, stored state on step
            always_comb begin
                rin  = load ? st_in : st_q;
                wsel = load ? wk_i[WORD_W-1:0] : wk1_q;
            end

            sha2r_round u_r (.cur(rin), .wk(wsel), .nxt(st_d));
            assign st_en = load | step;

            // R4
            shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> (st_q.b == $past(st_q.a)) && (st_q.c == $past(st_q.b)) &&
                         (st_q.f == $past(st_q.e)) && (st_q.h == $past(st_q.g)));
        end
    endgenerate

    // state register, updated only when a round is applied
    always_ff @(posedge clk) begin
        if (!rst_n)     st_q <= '0;
        else if (st_en) st_q <= st_d;
    end

    // R2
    fast_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FAST && load) |=> (st_q.c == $past(abef_i[4*WORD_W-1:3*WORD_W])) &&
                           (st_q.h == $past(abef_i[WORD_W-1:0])));
endmodule

// File: rtl/sha2r_ctrl.sv
// Start/done sequencing. It accepts a start only while idle.
// The iterative variant spends one busy cycle between acceptance and done.
module sha2r_ctrl #(
    parameter bit FAST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept,
    output logic step,
    output logic busy_o,
    output logic done_o
);
    logic busy_q;
    logic done_q;

    assign accept = start_i & ~busy_q;
    assign step   = busy_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // track the pending round and the result-valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (FAST) begin
            busy_q <= 1'b0;
            done_q <= accept;
        end else begin
            busy_q <= accept;
            done_q <= busy_q;
        end
    end

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o}));

    // R5
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (FAST ? done_o : (busy_o && !done_o)));

    // R5
    busy_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (done_o && !busy_o));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !busy_o);
endmodule

// File: rtl/sha2r_twinround.sv
// Top level: two SHA-512 rounds per invocation on a split half-state.
// The result is the A,B,E,F half. The caller reuses the old A,B,E,F as the next C,D,G,H.
// ONE_CYCLE selects the chained variant; the default applies one round per cycle.
module sha2r_twinround
    import sha2r_pkg::*;
#(
    parameter bit ONE_CYCLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [HALF_W-1:0] abef_i,
    input  logic [HALF_W-1:0] cdgh_i,
    input  logic [WK_W-1:0]   wk_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [HALF_W-1:0] abef_o
);
    logic accept;
    logic step;
    st8_t st_q;

    sha2r_ctrl #(.FAST(ONE_CYCLE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .accept(accept), .step(step), .busy_o(busy_o), .done_o(done_o)
    );

    sha2r_datapath #(.FAST(ONE_CYCLE)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
        .abef_i(abef_i), .cdgh_i(cdgh_i), .wk_i(wk_i), .st_q(st_q)
    );

    // repack the A,B,E,F words of the state
    assign abef_o = {st_q.a, st_q.b, st_q.e, st_q.f};

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !busy_o) |=> $stable(abef_o));
endmodule

// File: tb/tb_sha2r_twinround.sv
module tb_sha2r_twinround;
    localparam int PERIOD = 10;
    localparam int NVEC   = 4;

    typedef logic [63:0] w64;

    // operand table: abef, cdgh, wk (expected results come from the model below)
    localparam logic [639:0] VEC [NVEC] = '{
        {256'h0, 256'h0, 128'h0},
        {{4{64'hffffffffffffffff}}, {4{64'hffffffffffffffff}}, {2{64'hffffffffffffffff}}},
        {256'h0123456789abcdef_fedcba9876543210_0f0f0f0f0f0f0f0f_f0f0f0f0f0f0f0f0,
         256'h1111111111111111_2222222222222222_3333333333333333_4444444444444444,
         128'h8000000000000001_0000000000000007},
        {256'hdeadbeefcafef00d_0badc0de12345678_a5a5a5a55a5a5a5a_7fffffffffffffff,
         256'h8000000000000000_0000000000000001_fffffffffffffffe_0123012301230123,
         128'h0000000000000000_ffffffffffffffff}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_s = 1'b0, start_f = 1'b0;
    logic [255:0] abef_in = '0, cdgh_in = '0;
    logic [127:0] wk_in = '0;
    logic busy_s, done_s, busy_f, done_f;
    logic [255:0] res_s, res_f;
    int total = 0, bad = 0;

    always #(PERIOD/2) clk = ~clk;

    sha2r_twinround dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_s), .abef_i(abef_in),
        .cdgh_i(cdgh_in), .wk_i(wk_in), .busy_o(busy_s), .done_o(done_s), .abef_o(res_s));

    sha2r_twinround #(.ONE_CYCLE(1'b1)) dut_fast (
        .clk(clk), .rst_n(rst_n), .start_i(start_f), .abef_i(abef_in),
        .cdgh_i(cdgh_in), .wk_i(wk_in), .busy_o(busy_f), .done_o(done_f), .abef_o(res_f));

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic w64 rr(input w64 x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    // reference model written from R1..R4
    function automatic logic [255:0] model(input logic [255:0] ab, input logic [255:0] cd, input logic [127:0] wk);
        w64 s [8];
        s[0] = ab[255:192]; s[1] = ab[191:128]; s[4] = ab[127:64]; s[5] = ab[63:0];
        s[2] = cd[255:192]; s[3] = cd[191:128]; s[6] = cd[127:64]; s[7] = cd[63:0];
        for (int r = 0; r < 2; r++) begin
            w64 k  = (r == 0) ? wk[63:0] : wk[127:64];
            w64 t1 = ((s[4] & s[5]) ^ (~s[4] & s[6])) + (rr(s[4],14) ^ rr(s[4],18) ^ rr(s[4],41)) + k + s[7];
            w64 t2 = ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2])) + (rr(s[0],28) ^ rr(s[0],34) ^ rr(s[0],39));
            s[7] = s[6]; s[6] = s[5]; s[5] = s[4]; s[4] = s[3] + t1;
            s[3] = s[2]; s[2] = s[1]; s[1] = s[0]; s[0] = t1 + t2;
        end
        return {s[0], s[1], s[4], s[5]};
    endfunction

    // one invocation with latency and handshake checks (R5, R10)
    task automatic invoke(input bit fast, input logic [255:0] ab, input logic [255:0] cd,
                          input logic [127:0] wk, output logic [255:0] res);
        abef_in = ab; cdgh_in = cd; wk_in = wk;
        if (fast) start_f = 1'b1; else start_s = 1'b1;
        @(negedge clk);
        start_f = 1'b0; start_s = 1'b0;
        if (fast) begin
            chk(done_f && !busy_f, "R5 fast done", {busy_f, done_f}, 2'b01);
            res = res_f;
        end else begin
            chk(busy_s && !done_s, "R5 iter busy", {busy_s, done_s}, 2'b10);
            @(negedge clk);
            chk(done_s && !busy_s, "R10 iter done", {busy_s, done_s}, 2'b01);
            res = res_s;
        end
    endtask

    function automatic w64 frac_cbrt(input int p);
        logic [255:0] n = 256'(p) << 192;
        logic [255:0] r = '0;
        for (int b = 67; b >= 0; b--) begin
            logic [255:0] t = r | (256'd1 << b);
            if (t * t * t <= n) r = t;
        end
        return r[63:0];
    endfunction

    function automatic w64 frac_sqrt(input int p);
        logic [255:0] n = 256'(p) << 128;
        logic [255:0] r = '0;
        for (int b = 67; b >= 0; b--) begin
            logic [255:0] t = r | (256'd1 << b);
            if (t * t <= n) r = t;
        end
        return r[63:0];
    endfunction

    // R9: full 80-round "abc" block through 40 invocations
    task automatic run_abc(input bit fast);
        int primes [80];
        w64 kc [80];
        w64 w [80];
        w64 h0 [8];
        logic [255:0] ab, cd, nx, d_hi, d_lo;
        int cnt = 0;
        for (int c = 2; cnt < 80; c++) begin
            bit is_p = 1'b1;
            for (int q = 2; q * q <= c; q++) if (c % q == 0) is_p = 1'b0;
            if (is_p) begin primes[cnt] = c; cnt++; end
        end
        for (int i = 0; i < 80; i++) kc[i] = frac_cbrt(primes[i]);
        for (int i = 0; i < 8; i++) h0[i] = frac_sqrt(primes[i]);
        for (int i = 0; i < 16; i++) w[i] = '0;
        w[0] = 64'h6162638000000000;
        w[15] = 64'd24;
        for (int i = 16; i < 80; i++)
            w[i] = (rr(w[i-2],19) ^ rr(w[i-2],61) ^ (w[i-2] >> 6)) + w[i-7]
                 + (rr(w[i-15],1) ^ rr(w[i-15],8) ^ (w[i-15] >> 7)) + w[i-16];
        ab = {h0[0], h0[1], h0[4], h0[5]};
        cd = {h0[2], h0[3], h0[6], h0[7]};
        for (int j = 0; j < 40; j++) begin
            invoke(fast, ab, cd, {w[2*j+1] + kc[2*j+1], w[2*j] + kc[2*j]}, nx);
            cd = ab;
            ab = nx;
        end
        d_hi = {ab[255:192] + h0[0], ab[191:128] + h0[1], cd[255:192] + h0[2], cd[191:128] + h0[3]};
        d_lo = {ab[127:64] + h0[4], ab[63:0] + h0[5], cd[127:64] + h0[6], cd[63:0] + h0[7]};
        chk(d_hi == 256'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a,
            "R9 digest high", d_hi, 256'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a);
        chk(d_lo == 256'h2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f,
            "R9 digest low", d_lo, 256'h2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f);
    endtask

    initial begin
        logic [255:0] got, exp, held;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(!busy_s && !done_s && res_s == '0, "R8 reset iter", res_s, 256'h0);
        chk(!busy_f && !done_f && res_f == '0, "R8 reset fast", res_f, 256'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 in both variants
        for (int v = 0; v < NVEC; v++) begin
            exp = model(VEC[v][639:384], VEC[v][383:128], VEC[v][127:0]);
            invoke(1'b0, VEC[v][639:384], VEC[v][383:128], VEC[v][127:0], got);
            chk(got == exp, "R1 R2 R3 R4 iter vector", got, exp);
            invoke(1'b1, VEC[v][639:384], VEC[v][383:128], VEC[v][127:0], got);
            chk(got == exp, "R1 R2 R3 R4 fast vector", got, exp);
        end

        // R3: swapped WK halves must follow the model, not the original order
        exp = model(VEC[2][639:384], VEC[2][383:128], {VEC[2][63:0], VEC[2][127:64]});
        invoke(1'b0, VEC[2][639:384], VEC[2][383:128], {VEC[2][63:0], VEC[2][127:64]}, got);
        chk(got == exp, "R3 wk order", got, exp);

        // R6: start during busy is ignored
        exp = model(VEC[2][639:384], VEC[2][383:128], VEC[2][127:0]);
        abef_in = VEC[2][639:384]; cdgh_in = VEC[2][383:128]; wk_in = VEC[2][127:0];
        start_s = 1'b1;
        @(negedge clk);
        abef_in = VEC[3][639:384]; cdgh_in = VEC[3][383:128]; wk_in = VEC[3][127:0];
        @(negedge clk);
        start_s = 1'b0;
        chk(done_s && res_s == exp, "R6 busy start ignored", res_s, exp);
        @(negedge clk);
        chk(!done_s && !busy_s, "R6 no extra done", {busy_s, done_s}, 2'b00);

        // R7: result held while idle
        held = res_s;
        repeat (3) @(negedge clk);
        chk(res_s == held && !done_s, "R7 result held", res_s, held);

        run_abc(1'b0);
        run_abc(1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule